// File: doc/BRIEF.md
# Sub-Epoch Checkpoint Sequencer

This block runs beside one processor that executes a speculative epoch. When the epoch begins, it loads a context identifier from the epoch's base number. Base numbers are handed out with unused gaps between them, and the sequencer rounds the given base down to the start of its gap. While the epoch runs, the block counts retired instructions. After a fixed number of retirements it opens a new sub-epoch. It does this by advancing the context identifier to the next number inside the gap and pulsing a strobe, which tells the register checkpoint store to save state.

Each sub-epoch uses one more epoch context, so the gap size limits how many sub-epochs one epoch can have. Once the last number in the gap is reached, the sequencer stays on it and starts no further sub-epochs.

A violation report names one context. If that context belongs to the running epoch and has already been opened, the sequencer rewinds to it. It reports the context to roll back to, makes it current again, and restarts the instruction count. Violations that name contexts outside the epoch, or contexts not yet opened, are dropped. A commit frees every context of the epoch at once and returns the block to idle.

Top module: `subepoch_seq`

## Requirements
- R1: After reset, `busy`, `ckpt_strobe` and `rollback_valid` are 0 and `ctx_id` and `rollback_ctx` are 0.
- R2: `epoch_start` while idle makes `busy` 1 on the next cycle, with `ctx_id` equal to `epoch_base` with its low GAP_LOG2 bits cleared. `epoch_start` while busy has no effect.
- R3: While busy, on the cycle after every INTERVAL-th counted `retire` pulse, `ctx_id` is one higher than before and `ckpt_strobe` is 1 for exactly that one cycle. `ckpt_strobe` is never 1 at any other time.
- R4: When the low GAP_LOG2 bits of `ctx_id` are all ones (the gap is used up), further retirements neither change `ctx_id` nor raise `ckpt_strobe`.
- R5: A `violate` while busy is accepted if its `violate_ctx` has the same upper bits (above GAP_LOG2) as `ctx_id` and low bits no greater than those of `ctx_id`. On the next cycle, `ctx_id` and `rollback_ctx` equal `violate_ctx` and `rollback_valid` pulses for one cycle. The retirement count restarts from zero.
- R6: A `violate` naming another epoch's gap, a sub-epoch above the current one, or arriving while idle has no effect on any output.
- R7: `commit` while busy makes `busy` 0 on the next cycle and leaves `ctx_id` unchanged. Retirements while idle change nothing.
- R8: In one cycle, `commit` takes precedence over `violate`, and an accepted `violate` takes precedence over `retire`: the retire that coincides with it is not counted.
- R9: While an epoch stays busy, the bits of `ctx_id` above GAP_LOG2 never change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| epoch_start | input | 1 | Start of a speculative epoch |
| epoch_base | input | CTX_W | Base epoch number for the starting epoch |
| retire | input | 1 | One instruction retired this cycle |
| commit | input | 1 | Epoch commits; all its contexts are released |
| violate | input | 1 | A violation is reported this cycle |
| violate_ctx | input | CTX_W | Context identifier that was violated |
| busy | output | 1 | An epoch is being sequenced |
| ctx_id | output | CTX_W | Current epoch-context identifier |
| ckpt_strobe | output | 1 | One-cycle request to take a register checkpoint |
| rollback_valid | output | 1 | One-cycle pulse: rewind to `rollback_ctx` |
| rollback_ctx | output | CTX_W | Context to restore after a violation |

## Verification
The bench builds the block with CTX_W=6, GAP_LOG2=2 and INTERVAL=3. With these values a gap holds four sub-epochs and each sub-epoch lasts three retirements, so a short run can use up a gap and then keep retiring instructions. A small interval also lets a violation fall partway through a count, which shows that the count restarts, and lets a violation land on the same cycle as a boundary retirement, which shows the priority between them. With only six identifier bits, a neighbouring epoch's gap is easy to name, which exercises rejection by the upper bits.

// File: rtl/subepoch_pkg.sv
package subepoch_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/subepoch_interval.sv
// Counts retirements and flags the last one of each interval.
module subepoch_interval #(
  parameter int INTERVAL = 5000,
  localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic tick,
  output logic expire
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == LAST);
  assign expire = tick && at_end && !clear;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_end ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/subepoch_ctx_alloc.sv
// Holds the current context identifier inside the epoch's gap.
module subepoch_ctx_alloc #(
  parameter int CTX_W    = 8,
  parameter int GAP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CTX_W-1:0] load_base,
  input  logic             restore,
  input  logic [CTX_W-1:0] restore_ctx,
  input  logic             advance,
  input  logic [CTX_W-1:0] probe_ctx,
  output logic             probe_hit,
  output logic             last,
  output logic [CTX_W-1:0] ctx_q
);
  localparam logic [CTX_W-1:0] SUB_MASK = CTX_W'((1 << GAP_LOG2) - 1);

  logic [CTX_W-1:0] sub_cur;
  logic [CTX_W-1:0] sub_probe;

  assign sub_cur   = ctx_q & SUB_MASK;
  assign sub_probe = probe_ctx & SUB_MASK;
  assign last      = (sub_cur == SUB_MASK);
  assign probe_hit = ((probe_ctx & ~SUB_MASK) == (ctx_q & ~SUB_MASK))
                     && (sub_probe <= sub_cur);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctx_q <= '0;
    end else if (load) begin
      ctx_q <= load_base & ~SUB_MASK;
    end else if (restore) begin
      ctx_q <= restore_ctx;
    end else if (advance && !last) begin
      ctx_q <= ctx_q + 1'b1;
    end
  end
endmodule

// File: rtl/subepoch_seq_chk.sv
module subepoch_seq_chk #(
  parameter int CTX_W    = 8,
  parameter int GAP_LOG2 = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic [CTX_W-1:0] ctx_id,
  input logic             ckpt_strobe,
  input logic             rollback_valid,
  input logic [CTX_W-1:0] rollback_ctx
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (!busy && !ckpt_strobe && !rollback_valid));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst) ckpt_strobe |=> !ckpt_strobe);

  // R3
  strobe_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ckpt_strobe && $past(busy)) |-> (ctx_id == $past(ctx_id) + 1'b1));

  // R3
  strobe_busy_chk: assert property (@(posedge clk) disable iff (rst) ckpt_strobe |-> busy);

  // R5
  rollback_ctx_chk: assert property (@(posedge clk) disable iff (rst) rollback_valid |-> (ctx_id == rollback_ctx));

  // R8
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst) !(ckpt_strobe && rollback_valid));

  // R9
  gap_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(rst)) |-> ((ctx_id >> GAP_LOG2) == ($past(ctx_id) >> GAP_LOG2)));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(rst)) |-> $stable(ctx_id));
endmodule

bind subepoch_seq subepoch_seq_chk #(.CTX_W(CTX_W), .GAP_LOG2(GAP_LOG2)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .ctx_id(ctx_id), .ckpt_strobe(ckpt_strobe),
  .rollback_valid(rollback_valid), .rollback_ctx(rollback_ctx)
);

// File: rtl/subepoch_seq.sv
module subepoch_seq #(
  parameter int CTX_W    = 8,
  parameter int GAP_LOG2 = 3,
  parameter int INTERVAL = 5000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             epoch_start,
  input  logic [CTX_W-1:0] epoch_base,
  input  logic             retire,
  input  logic             commit,
  input  logic             violate,
  input  logic [CTX_W-1:0] violate_ctx,
  output logic             busy,
  output logic [CTX_W-1:0] ctx_id,
  output logic             ckpt_strobe,
  output logic             rollback_valid,
  output logic [CTX_W-1:0] rollback_ctx
);
  import subepoch_pkg::*;

  seq_state_t state_q;
  logic       run;
  logic       do_start, do_commit, do_viol, do_tick;
  logic       expire, probe_hit, last, advance;
  logic       strobe_q, rb_q;
  logic [CTX_W-1:0] rbctx_q;

  assign run       = (state_q == SEQ_RUN);
  assign do_commit = run && commit;
  assign do_viol   = run && !commit && violate && probe_hit;
  assign do_start  = !run && epoch_start;
  assign do_tick   = run && !commit && !do_viol && retire;
  assign advance   = expire && !last;

  subepoch_interval #(.INTERVAL(INTERVAL)) u_interval (
    .clk(clk), .rst(rst), .clear(do_start || do_viol), .tick(do_tick), .expire(expire)
  );

  subepoch_ctx_alloc #(.CTX_W(CTX_W), .GAP_LOG2(GAP_LOG2)) u_alloc (
    .clk(clk), .rst(rst), .load(do_start), .load_base(epoch_base),
    .restore(do_viol), .restore_ctx(violate_ctx), .advance(advance),
    .probe_ctx(violate_ctx), .probe_hit(probe_hit), .last(last), .ctx_q(ctx_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= SEQ_IDLE;
      strobe_q <= 1'b0;
      rb_q     <= 1'b0;
      rbctx_q  <= '0;
    end else begin
      if (do_start) begin
        state_q <= SEQ_RUN;
      end else if (do_commit) begin
        state_q <= SEQ_IDLE;
      end
      strobe_q <= advance;
      rb_q     <= do_viol;
      if (do_viol) begin
        rbctx_q <= violate_ctx;
      end
    end
  end

  assign busy           = run;
  assign ckpt_strobe    = strobe_q;
  assign rollback_valid = rb_q;
  assign rollback_ctx   = rbctx_q;
endmodule

// File: tb/subepoch_seq_bench.sv
module subepoch_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W   = 6;
  localparam int G   = 2;
  localparam int GAP = 1 << G;
  localparam int INT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic epoch_start = 1'b0, retire = 1'b0, commit = 1'b0, violate = 1'b0;
  logic [W-1:0] epoch_base = '0, violate_ctx = '0;
  logic busy, ckpt_strobe, rollback_valid;
  logic [W-1:0] ctx_id, rollback_ctx;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // reference model state
  int m_busy = 0, m_ctx = 0, m_cnt = 0, m_strobe = 0, m_rb = 0, m_rbctx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subepoch_seq #(.CTX_W(W), .GAP_LOG2(G), .INTERVAL(INT)) u_subepoch_seq (
    .clk(clk), .rst(rst), .epoch_start(epoch_start), .epoch_base(epoch_base),
    .retire(retire), .commit(commit), .violate(violate), .violate_ctx(violate_ctx),
    .busy(busy), .ctx_id(ctx_id), .ckpt_strobe(ckpt_strobe),
    .rollback_valid(rollback_valid), .rollback_ctx(rollback_ctx)
  );

  always @(posedge clk) begin
    int vc;
    vc = int'(violate_ctx);
    cycles++;
    if (rst) begin
      m_busy = 0; m_ctx = 0; m_cnt = 0; m_strobe = 0; m_rb = 0; m_rbctx = 0;
    end else begin
      m_strobe = 0;
      m_rb = 0;
      if (m_busy != 0 && commit) begin
        m_busy = 0;
      end else if (m_busy != 0 && violate && (vc / GAP) == (m_ctx / GAP)
                   && (vc % GAP) <= (m_ctx % GAP)) begin
        m_ctx = vc; m_cnt = 0; m_rb = 1; m_rbctx = vc;
      end else if (m_busy == 0 && epoch_start) begin
        m_busy = 1; m_ctx = (int'(epoch_base) / GAP) * GAP; m_cnt = 0;
      end else if (m_busy != 0 && retire) begin
        if (m_cnt == INT - 1) begin
          m_cnt = 0;
          if ((m_ctx % GAP) < GAP - 1) begin
            m_ctx++; m_strobe = 1;
          end
        end else begin
          m_cnt++;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare against the model every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 busy vs model", int'(busy), m_busy);
      chk("R3 ctx_id vs model", int'(ctx_id), m_ctx);
      chk("R3 ckpt_strobe vs model", int'(ckpt_strobe), m_strobe);
      chk("R5 rollback_valid vs model", int'(rollback_valid), m_rb);
      chk("R5 rollback_ctx vs model", int'(rollback_ctx), m_rbctx);
    end
  end

  task automatic cyc(input logic st, input int base, input logic ret,
                     input logic com, input logic vio, input int vctx);
    epoch_start = st; epoch_base = W'(base); retire = ret;
    commit = com; violate = vio; violate_ctx = W'(vctx);
    @(negedge clk);
    epoch_start = 0; retire = 0; commit = 0; violate = 0;
  endtask

  task automatic retires(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 0, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 ctx_id", int'(ctx_id), 0);
    chk("R1 strobes", int'(ckpt_strobe) + int'(rollback_valid), 0);

    cyc(1, 13, 0, 0, 0, 0);
    chk("R2 aligned base", int'(ctx_id), 12);
    chk("R2 busy", int'(busy), 1);

    retires(2);
    chk("R3 no strobe early", int'(ckpt_strobe), 0);
    retires(1);
    chk("R3 strobe", int'(ckpt_strobe), 1);
    chk("R3 ctx step", int'(ctx_id), 13);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R3 strobe one cycle", int'(ckpt_strobe), 0);

    retires(6);
    chk("R4 last sub-epoch", int'(ctx_id), 15);
    retires(4);
    chk("R4 exhausted hold", int'(ctx_id), 15);
    chk("R4 no strobe", int'(ckpt_strobe), 0);

    cyc(0, 0, 0, 0, 1, 9);
    chk("R6 other gap ignored", int'(rollback_valid), 0);
    chk("R6 ctx kept", int'(ctx_id), 15);
    cyc(0, 0, 0, 0, 1, 14);
    chk("R5 rollback pulse", int'(rollback_valid), 1);
    chk("R5 rollback ctx", int'(rollback_ctx), 14);
    chk("R5 ctx rewound", int'(ctx_id), 14);

    cyc(1, 40, 0, 0, 0, 0);
    chk("R2 start while busy ignored", int'(ctx_id), 14);

    retires(2);
    cyc(0, 0, 0, 0, 1, 13);
    chk("R5 rewind to 13", int'(ctx_id), 13);
    retires(2);
    chk("R5 count restarted", int'(ckpt_strobe), 0);
    retires(1);
    chk("R5 strobe after full interval", int'(ckpt_strobe), 1);
    chk("R9 upper bits kept", int'(ctx_id) / GAP, 3);

    cyc(0, 0, 0, 0, 1, 15);
    chk("R6 future sub-epoch ignored", int'(ctx_id), 14);
    chk("R6 no rollback", int'(rollback_valid), 0);

    cyc(0, 0, 1, 1, 1, 12);
    chk("R8 commit wins", int'(busy), 0);
    chk("R8 no rollback on commit", int'(rollback_valid), 0);
    chk("R7 ctx held", int'(ctx_id), 14);
    retires(5);
    chk("R7 idle retires", int'(ctx_id), 14);
    cyc(0, 0, 0, 0, 1, 12);
    chk("R6 idle violation ignored", int'(rollback_valid), 0);

    cyc(1, 40, 0, 0, 0, 0);
    chk("R2 second epoch", int'(ctx_id), 40);
    retires(2);
    cyc(0, 0, 1, 0, 1, 40);
    chk("R8 violation over retire", int'(ckpt_strobe), 0);
    chk("R8 rollback taken", int'(rollback_ctx), 40);
    retires(3);
    chk("R8 retire not counted", int'(ctx_id), 41);

    retires(2);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 mid-epoch reset busy", int'(busy), 0);
    chk("R1 mid-epoch reset ctx", int'(ctx_id), 0);
    retires(4);
    chk("R7 idle after reset", int'(ctx_id), 0);

    finish_run();
  end
endmodule